// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port and an external asynchronous static RAM with a 16-bit data bus. The RAM has active-low chip select, write strobe, output enable and per-byte lane enables. A client hands over one read or write at a time on a valid/ready handshake. Each request carries an address, a write word and a byte-lane mask. The controller then plays out the pin sequence for that access and waits the time each phase needs. For reads it returns the captured word with a one-cycle valid strobe.

The phase lengths are not fixed numbers. Each one is derived at elaboration from nanosecond constraints and a clock-period parameter. Each constraint becomes a cycle count, rounded up, and a nonzero constraint always gives at least one cycle. A write holds its strobe low long enough for the pulse width, the data setup and the address setup together. The strobe is then raised while address, data and lanes stay put, which ends the write cleanly. A read keeps the output enable low for the access time and samples the data before the address moves. A quiet gap follows every read so that the memory has released the bus before the controller drives it. The data pins are split into an input, an output and an output-enable, so a pad ring or the bench builds the tristate. Reset is asynchronous, active low, and assumed to be released in step with the clock.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block shows ready high, rsp_valid low, sram_ce_n, sram_we_n, sram_oe_n and both sram_be_n bits high, and sram_dq_oe low.
- R2: A write with a nonzero mask holds sram_we_n low for exactly WP cycles, starting in the cycle after acceptance. WP is the largest of the rounded write-pulse, data-setup and address-setup counts, which is 6 at an 8 ns clock. During those cycles sram_ce_n is low, sram_dq_oe is high, and address, data and lanes do not change. All of these stay unchanged for at least one further cycle after sram_we_n rises.
- R3: Mask bit 0 drives sram_be_n[0], which covers data bits 7:0, and mask bit 1 drives sram_be_n[1], which covers data bits 15:8. A lane is enabled when its mask bit is 1. A write changes only the enabled bytes, and a read returns zero in the bytes that were not enabled.
- R4: A read with a nonzero mask holds sram_ce_n and sram_oe_n low, sram_we_n high and the address steady for exactly RD cycles after acceptance. RD is the largest of the rounded read-cycle, address-access and output-enable-access counts, which is 7 at 8 ns. The word on sram_dq_i in the last of those cycles is returned on rsp_rdata. rsp_valid is high for that single cycle, RD+1 cycles after the cycle of acceptance.
- R5: After a read, ready stays low and sram_dq_oe stays low for TA cycles after sram_oe_n rises. TA is the rounded bus-release time with a minimum of one, which is 3 at 8 ns.
- R6: Ready is high only while idle, and no strobe is active and the data bus is not driven while ready is high. A write keeps ready low for WP+WR cycles after acceptance, where WR = max(1, rounded write cycle − WP). A read keeps ready low for RD+TA cycles.
- R7: A request with mask 0 asserts none of sram_we_n, sram_oe_n or sram_ce_n and keeps ready low for one cycle. A read with mask 0 returns rsp_valid with rsp_rdata equal to zero in that following cycle.
- R8: Every cycle count is ceil(ns / CLK_NS), and a nonzero constraint yields at least one cycle. With the defaults this gives write busy 7 cycles and read busy 10 cycles.
- R9: sram_dq_oe is never high while sram_oe_n is low, and sram_we_n and sram_oe_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_mask | input | DATA_W/8 | Byte-lane mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read word, disabled bytes zero |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| sram_dq_o | output | DATA_W | Data driven toward memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | DATA_W | Data read from memory pins |

## Verification
The assertions watch pin relations on every cycle. They check that a write strobe only appears with chip select, lanes and driven data, and that address and data stay frozen while the strobe or output enable is low and in the cycle the strobe rises. They also check that the bus is never driven during or too soon after an output-enable window, and that nothing is active while ready is high. Only the bench scenarios can show the exact phase lengths, busy times and response position that follow from the nanosecond parameters. The same holds for the byte-lane effect on stored and returned data, and for the handling of a zero mask. The bench shows these with a memory model that returns garbage when sampled before the access time and that records any write pulse shorter than the derived length.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_WREC   = 3'd2,
    ST_RACC   = 3'd3,
    ST_RTURN  = 3'd4,
    ST_SKIP   = 3'd5
  } ctl_state_e;

  // Round a nanosecond constraint up to whole clock cycles.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    return (ns == 0) ? 0 : (ns + per - 1) / per;
  endfunction

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_phase_cnt.sv
module sram_ctl_phase_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load | ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= load ? load_val : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WP_CYC   = 6,
  parameter int unsigned WREC_CYC = 1,
  parameter int unsigned TA_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_mask_zero,
  input  logic             cnt_done,
  output ctl_state_e       state_q,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept
);

  ctl_state_e state_d;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_mask_zero) begin
            state_d = ST_SKIP;
          end else if (req_write) begin
            state_d  = ST_WPULSE;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(WP_CYC - 1);
          end else begin
            state_d  = ST_RACC;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WPULSE: begin
        if (cnt_done) begin
          state_d  = ST_WREC;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(WREC_CYC - 1);
        end
      end
      ST_RACC: begin
        if (cnt_done) begin
          state_d  = ST_RTURN;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(TA_CYC - 1);
        end
      end
      ST_WREC, ST_RTURN: begin
        if (cnt_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              zero_en,
  input  logic [BE_W-1:0]   lane_sel,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] keep;
  logic              data_en;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign keep[g*8 +: 8] = {8{lane_sel[g]}};
  end

  assign data_en = cap_en | zero_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= data_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (data_en) begin
      rsp_rdata <= cap_en ? (dq_i & keep) : '0;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_DOE_NS = 25,
  parameter int unsigned T_PWE_NS = 45,
  parameter int unsigned T_WC_NS  = 55,
  parameter int unsigned T_SD_NS  = 25,
  parameter int unsigned T_AW_NS  = 45,
  parameter int unsigned T_HZ_NS  = 20,
  localparam int unsigned BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [BE_W-1:0]   sram_be_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned RD_CYC = cyc_max(
      cyc_max(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
      cyc_max(ns2cyc(T_DOE_NS, CLK_NS), 1));
  localparam int unsigned WP_CYC = cyc_max(
      cyc_max(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
      cyc_max(ns2cyc(T_AW_NS, CLK_NS), 1));
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WREC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned TA_CYC   = cyc_max(ns2cyc(T_HZ_NS, CLK_NS), 1);
  localparam int unsigned CNT_MAX  = cyc_max(cyc_max(RD_CYC, WP_CYC), cyc_max(WREC_CYC, TA_CYC));
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  ctl_state_e        state_q;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_val;
  logic              cnt_done;
  logic              accept;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   mask_q;
  logic              write_q;

  logic              wr_phase;
  logic              mem_sel;

  // Request capture, clock-enabled on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      write_q <= req_write;
    end
  end

  sram_ctl_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .WREC_CYC(WREC_CYC),
    .TA_CYC  (TA_CYC)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_mask_zero(~|req_mask),
    .cnt_done     (cnt_done),
    .state_q      (state_q),
    .cnt_load     (cnt_load),
    .cnt_val      (cnt_val),
    .accept       (accept)
  );

  sram_ctl_phase_cnt #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .done    (cnt_done)
  );

  sram_ctl_rdcap #(
    .DATA_W(DATA_W),
    .BE_W  (BE_W)
  ) rdcap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   ((state_q == ST_RACC) && cnt_done),
    .zero_en  ((state_q == ST_SKIP) && !write_q),
    .lane_sel (mask_q),
    .dq_i     (sram_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  // Pin decode from the registered state.
  assign wr_phase   = (state_q == ST_WPULSE) || (state_q == ST_WREC);
  assign mem_sel    = wr_phase || (state_q == ST_RACC);

  assign req_ready  = (state_q == ST_IDLE);
  assign sram_addr  = addr_q;
  assign sram_ce_n  = ~mem_sel;
  assign sram_we_n  = (state_q != ST_WPULSE);
  assign sram_oe_n  = (state_q != ST_RACC);
  assign sram_be_n  = mem_sel ? ~mask_q : '1;
  assign sram_dq_o  = wdata_q;
  assign sram_dq_oe = wr_phase;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_NS  = 8,
  parameter int unsigned T_HZ_NS = 20,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [BE_W-1:0]   be_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_o
);

  localparam int unsigned GAP_LIM = cyc_max(ns2cyc(T_HZ_NS, CLK_NS), 1);
  localparam int unsigned GAP_W   = $clog2(GAP_LIM + 1) + 1;

  // Cycles since the output enable last went high, saturating.
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_W'(GAP_LIM);
    end else if (!oe_n) begin
      gap_q <= '0;
    end else if (gap_q < GAP_W'(GAP_LIM)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r2_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && dq_oe && !(&be_n)));

  a_r2_frozen_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_o) && $stable(be_n)));

  a_r2_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (!ce_n && dq_oe && $stable(addr) && $stable(dq_o) && $stable(be_n)));

  a_r4_addr_steady_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && $past(!oe_n)) |-> ($stable(addr) && !ce_n && $stable(be_n)));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (gap_q >= GAP_W'(GAP_LIM)));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && oe_n && !dq_oe));

  a_r9_no_drive_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!dq_oe && we_n));

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CLK_NS (CLK_NS),
  .T_HZ_NS(T_HZ_NS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ce_n     (sram_ce_n),
  .we_n     (sram_we_n),
  .oe_n     (sram_oe_n),
  .be_n     (sram_be_n),
  .dq_oe    (sram_dq_oe),
  .addr     (sram_addr),
  .dq_o     (sram_dq_o)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

  // Expected cycle counts worked out from the nanosecond figures (R8).
  function automatic int cdiv(input int ns, input int per);
    return (ns == 0) ? 0 : (ns + per - 1) / per;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PER  = 8;
  localparam int E_RD = imax(imax(cdiv(55, PER), cdiv(55, PER)), cdiv(25, PER));
  localparam int E_WP = imax(imax(cdiv(45, PER), cdiv(25, PER)), cdiv(45, PER));
  localparam int E_WR = imax(1, cdiv(55, PER) - E_WP);
  localparam int E_TA = imax(1, cdiv(20, PER));

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] sram_addr;
  logic        sram_ce_n;
  logic        sram_we_n;
  logic        sram_oe_n;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_o;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_i;

  int nchk;
  int nerr;
  int viol;
  int clash;
  int commits;
  bit finished;

  sram_ctl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .sram_be_n (sram_be_n),
    .sram_dq_o (sram_dq_o),
    .sram_dq_oe(sram_dq_oe),
    .sram_dq_i (sram_dq_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- memory model ----------------
  logic [15:0] mem     [0:63];
  logic [15:0] shadow  [0:63];
  int          acc_cnt;
  int          hz_cnt;
  int          wrun;
  logic [15:0] rword;

  function automatic logic [15:0] init_word(input int a);
    return 16'((a * 16'h0303) ^ 16'h5A3C);
  endfunction

  always_comb begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      rword = (acc_cnt >= E_RD - 1) ? mem[sram_addr[5:0]] : 16'hDEAD;
      sram_dq_i[7:0]  = sram_be_n[0] ? 8'hEE : rword[7:0];
      sram_dq_i[15:8] = sram_be_n[1] ? 8'hEE : rword[15:8];
    end else begin
      rword     = 16'h0;
      sram_dq_i = 16'hEEEE;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= 0;
      hz_cnt  <= 0;
      wrun    <= 0;
    end else begin
      if (!sram_ce_n && !sram_oe_n && sram_we_n) acc_cnt <= acc_cnt + 1;
      else acc_cnt <= 0;
      if (!sram_ce_n && !sram_oe_n) hz_cnt <= E_TA;
      else if (hz_cnt > 0) hz_cnt <= hz_cnt - 1;
      if (!sram_we_n && !sram_ce_n && !(&sram_be_n)) begin
        wrun <= wrun + 1;
      end else begin
        if (wrun > 0) begin
          if (wrun < E_WP || sram_ce_n) viol <= viol + 1;
          if (!sram_be_n[0]) mem[sram_addr[5:0]][7:0]  <= sram_dq_o[7:0];
          if (!sram_be_n[1]) mem[sram_addr[5:0]][15:8] <= sram_dq_o[15:8];
          commits <= commits + 1;
        end
        wrun <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && sram_dq_oe && ((!sram_oe_n && !sram_ce_n) || hz_cnt > 0)) clash <= clash + 1;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Called at a falling edge with ready high.
  task automatic xact(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input logic [1:0] m, output int busy, output int wec,
                      output int oec, output int dqc, output int rsp_i,
                      output logic [15:0] rd);
    busy = -1; wec = 0; oec = 0; dqc = 0; rsp_i = -1; rd = 16'h0;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (!sram_we_n) wec++;
      if (!sram_oe_n) oec++;
      if (sram_dq_oe) dqc++;
      if (rsp_valid) begin
        rsp_i = i;
        rd    = rsp_rdata;
      end
      if (req_ready) begin
        busy = i - 1;
        break;
      end
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int          busy, wec, oec, dqc, rsp_i;
    logic [15:0] rd, d, expw, keep;
    logic [15:0] a;
    nchk = 0; nerr = 0; viol = 0; clash = 0; commits = 0; finished = 1'b0;
    for (int k = 0; k < 64; k++) begin
      mem[k]    = init_word(k);
      shadow[k] = init_word(k);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R1 strobes in reset", int'({sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, rsp_valid}), 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'({req_ready, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, rsp_valid}), 8'b11111100);

    for (int ai = 0; ai < 16; ai++) begin
      a = 16'(ai * 257);
      for (int mi = 0; mi < 4; mi++) begin
        d = 16'((ai * 16'h1357) ^ (mi * 16'h2468) ^ 16'h0F0F);
        xact(1'b1, a, d, 2'(mi), busy, wec, oec, dqc, rsp_i, rd);
        if (mi == 0) begin
          chk("R7 zero-mask write busy", busy, 1);
          chk("R7 zero-mask write strobes", wec + oec + dqc, 0);
        end else begin
          chk("R6 R8 write busy", busy, E_WP + E_WR);
          chk("R2 write pulse length", wec, E_WP);
          chk("R9 no oe during write", oec, 0);
          if (mi[0]) shadow[ai][7:0]  = d[7:0];
          if (mi[1]) shadow[ai][15:8] = d[15:8];
        end
        // full-word readback (R3 lane effect on storage, R4 read path)
        xact(1'b0, a, 16'h0, 2'b11, busy, wec, oec, dqc, rsp_i, rd);
        chk("R6 R8 read busy", busy, E_RD + E_TA);
        chk("R4 oe window", oec, E_RD);
        chk("R4 response position", rsp_i, E_RD + 1);
        chk("R5 no drive during read", dqc, 0);
        chk("R3 R4 read data", int'(rd), int'(shadow[ai]));
        // partial-lane read with the same mask
        xact(1'b0, a, 16'h0, 2'(mi), busy, wec, oec, dqc, rsp_i, rd);
        if (mi == 0) begin
          chk("R7 zero-mask read busy", busy, 1);
          chk("R7 zero-mask read position", rsp_i, 2);
          chk("R7 zero-mask read data", int'(rd), 0);
          chk("R7 zero-mask read strobes", oec + wec, 0);
        end else begin
          keep = {{8{mi[1]}}, {8{mi[0]}}};
          expw = shadow[ai] & keep;
          chk("R3 masked read data", int'(rd), int'(expw));
          chk("R5 R6 masked read busy", busy, E_RD + E_TA);
        end
      end
    end

    chk("R2 write timing violations in model", viol, 0);
    chk("R2 R3 committed writes", commits, 48);
    chk("R9 R5 bus clashes", clash, 0);
    for (int k = 0; k < 16; k++) chk("R3 stored word", int'(mem[k]), int'(shadow[k]));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule